// File: doc/BRIEF.md
# Supply Undervoltage Detect Control

This block is the digital half of a supply-voltage monitor. Four analog comparators feed it. For each of the two supply ranges (3 V and 5 V) there is one comparator that flags "supply below the falling trip level" and one that flags "supply above the rising trip level". The block brings these asynchronous signals into the clock domain and picks the pair that belongs to the configured range. It keeps a hysteresis latch that marks the supply as improper, and from that latch it drives a polled status flag and a reset request.

Four configuration bits set how the block behaves:

- one picks the supply range;
- one powers the whole function down;
- one suppresses only the reset request;
- one decides whether detection keeps running while the chip is in stop mode.

The configuration inputs and the stop input are synchronous to the clock. The comparator inputs may change at any time.

Top module: `lvd_ctrl`

## Requirements
- R1: The status output `lv_status` is 1 for an improper supply and 0 for an acceptable one. When the selected falling comparator reports 1 (supply below the falling trip) and the block is enabled, `lv_status` is 1.
- R2: Once set, the latch stays set until the selected rising comparator reports 1 while the falling comparator reports 0. With both comparators at 0 the latch holds its value. With both at 1 the falling comparator wins and the latch sets.
- R3: `cfg_range_5v` = 1 selects the 5 V comparator pair and 0 selects the 3 V pair. The unselected pair has no effect on either output.
- R4: When `cfg_power_off` is 1, `lv_status` and `lv_reset_req` are 0 from the next clock edge onward. The latch is also reloaded to the improper state, so after power-up the status stays 1 until a good rising reading arrives.
- R5: When `cfg_reset_off` is 1, `lv_reset_req` is 0 on the next clock edge. `lv_status` keeps reporting normally.
- R6: In stop mode (`stop_in` = 1) with `cfg_stop_keep` = 0, both outputs are 0 from the next edge and the latch holds its value. With `cfg_stop_keep` = 1, stop mode has no effect.
- R7: `lv_reset_req` follows `lv_status` one clock later: it asserts one edge after the status is 1, and it is released on the first edge after the status returns to 0, provided the block is enabled and the reset is not disabled.
- R8: While `rst_n` is 0 at a clock edge, both outputs are 0. The latch starts in the improper state, so with the block enabled `lv_status` is 1 from the first edge after reset until a good rising reading is seen.
- R9: A comparator change takes effect at `lv_status` on the (SYNC_STAGES + 2)-th rising edge after it is sampled: synchronizer stages, then the latch, then the status register. With the default SYNC_STAGES = 2 this is the 4th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_fall_3v | input | 1 | Async: supply below 3 V falling trip |
| cmp_rise_3v | input | 1 | Async: supply above 3 V rising trip |
| cmp_fall_5v | input | 1 | Async: supply below 5 V falling trip |
| cmp_rise_5v | input | 1 | Async: supply above 5 V rising trip |
| cfg_range_5v | input | 1 | 1 = use 5 V pair, 0 = use 3 V pair |
| cfg_power_off | input | 1 | 1 = detect function powered down |
| cfg_reset_off | input | 1 | 1 = reset request suppressed |
| cfg_stop_keep | input | 1 | 1 = keep detecting in stop mode |
| stop_in | input | 1 | Chip is in stop mode |
| lv_status | output | 1 | Improper-supply flag (1 = improper) |
| lv_reset_req | output | 1 | Reset request to the reset controller |

## Verification
The assertions take for granted that the configuration and stop inputs change only in step with the clock. They also treat the synchronized comparator pair as arbitrary, including both comparators asserted at once, which a real analog front end would rarely produce. The stimulus changes every input just after the falling clock edge. It holds the comparator values for random stretches of a few cycles, so that settled states as well as fast toggling get through the synchronizers. It changes the configuration bits much less often, so that each mode is seen long enough to settle.

// File: rtl/lvd_pkg.sv
// Shared types for the undervoltage detect control logic.
// Assumes nothing beyond a single clock domain for the consumers.
package lvd_pkg;

    // One comparator pair after synchronization
    typedef struct packed {
        logic below_fall;   // supply under the falling trip
        logic above_rise;   // supply over the rising trip
    } lvd_pair_t;

    // Index of each comparator inside the raw synchronizer vector
    localparam int unsigned CMP_COUNT  = 4;
    localparam int unsigned IDX_RISE3  = 0;
    localparam int unsigned IDX_FALL3  = 1;
    localparam int unsigned IDX_RISE5  = 2;
    localparam int unsigned IDX_FALL5  = 3;

endpackage

// File: rtl/lvd_sync.sv
// Multi-bit, multi-stage synchronizer for independent asynchronous
// level signals. Each bit gets its own flop chain; no bus coherency is
// implied. Assumes STAGES >= 2. Resets to all zeros (synchronous).
module lvd_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous levels
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Shift towards the settled output
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/lvd_hyst.sv
// Hysteresis latch for the improper-supply condition. Sets when the
// falling comparator reports low supply (priority over the rising one),
// clears only when the rising comparator reports a good supply. Forced
// to the improper state when powered down or in reset; holds when frozen.
// Assumes the comparator pair is already synchronous.
module lvd_hyst
    import lvd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lvd_pair_t pair,
    input  logic      power_off,
    input  logic      freeze,
    output logic      improper
);

    // Latch update with fall-over-rise priority
    always_ff @(posedge clk) begin
        if (!rst_n)               improper <= 1'b1;
        else if (power_off)       improper <= 1'b1;
        else if (freeze)          improper <= improper;
        else if (pair.below_fall) improper <= 1'b1;
        else if (pair.above_rise) improper <= 1'b0;
    end

    // R2
    hyst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_off && !freeze && pair.below_fall) |=> improper);

    // R2
    hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_off && !pair.below_fall && !pair.above_rise) |=> $stable(improper));

    // R4
    hyst_pwr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_off |=> improper);

    // R6
    hyst_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_off && freeze) |=> $stable(improper));

endmodule

// File: rtl/lvd_gate.sv
// Output stage: registers the polled status from the latch and derives
// the reset request one cycle behind it. Both are gated by the enable
// (power and stop-mode) and the reset request also by its own disable.
// Assumes gating inputs are synchronous to clk.
module lvd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic improper,
    input  logic enable,
    input  logic reset_off,
    output logic status,
    output logic reset_req
);

    // Polled status flag
    always_ff @(posedge clk) begin
        if (!rst_n) status <= 1'b0;
        else        status <= improper & enable;
    end

    // Reset request trails the status by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) reset_req <= 1'b0;
        else        reset_req <= status & enable & ~reset_off;
    end

    // R7
    rst_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(status));

    // R5
    rst_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_off |=> !reset_req);

    // R4
    gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!status && !reset_req));

endmodule

// File: rtl/lvd_ctrl.sv
// Top of the undervoltage detect control. Synchronizes the four analog
// comparator outputs, selects the pair for the configured range, runs
// the hysteresis latch and drives status and reset request.
// Assumes cfg_* and stop_in are synchronous; comparators are not.
module lvd_ctrl
    import lvd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_fall_3v,
    input  logic cmp_rise_3v,
    input  logic cmp_fall_5v,
    input  logic cmp_rise_5v,
    input  logic cfg_range_5v,
    input  logic cfg_power_off,
    input  logic cfg_reset_off,
    input  logic cfg_stop_keep,
    input  logic stop_in,
    output logic lv_status,
    output logic lv_reset_req
);

    logic [CMP_COUNT-1:0] cmp_raw;
    logic [CMP_COUNT-1:0] cmp_sync;
    lvd_pair_t            pair_sel;
    logic                 freeze;
    logic                 enable;
    logic                 improper;

    assign cmp_raw[IDX_RISE3] = cmp_rise_3v;
    assign cmp_raw[IDX_FALL3] = cmp_fall_3v;
    assign cmp_raw[IDX_RISE5] = cmp_rise_5v;
    assign cmp_raw[IDX_FALL5] = cmp_fall_5v;

    lvd_sync #(
        .WIDTH  (CMP_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_raw),
        .sync_out (cmp_sync)
    );

    // Range select picks the comparator pair to act on
    always_comb begin
        if (cfg_range_5v) begin
            pair_sel.below_fall = cmp_sync[IDX_FALL5];
            pair_sel.above_rise = cmp_sync[IDX_RISE5];
        end else begin
            pair_sel.below_fall = cmp_sync[IDX_FALL3];
            pair_sel.above_rise = cmp_sync[IDX_RISE3];
        end
    end

    // Mode decode: stop without keep freezes, power-down disables
    assign freeze = stop_in & ~cfg_stop_keep;
    assign enable = ~cfg_power_off & ~freeze;

    lvd_hyst u_hyst (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair      (pair_sel),
        .power_off (cfg_power_off),
        .freeze    (freeze),
        .improper  (improper)
    );

    lvd_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .improper  (improper),
        .enable    (enable),
        .reset_off (cfg_reset_off),
        .status    (lv_status),
        .reset_req (lv_reset_req)
    );

    // R6
    stop_freeze_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_in && !cfg_stop_keep) |=> (!lv_status && !lv_reset_req));

endmodule

// File: tb/lvd_ctrl_test.sv
// Self-checking bench: directed corner cases, then seeded random
// stimulus, compared every cycle with a requirement-level model.
module lvd_ctrl_test;

    localparam int LAT = 2; // synchronizer stages (default)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f3 = 0, r3 = 0, f5 = 0, r5 = 0;
    logic rng5 = 0, pwr_off = 0, rst_off = 0, stop_keep = 0, stop = 0;
    logic lv_status, lv_reset_req;

    int checks = 0;
    int fails = 0;
    string cur_req = "R8";

    always #5 clk = ~clk;

    lvd_ctrl uut (
        .clk (clk), .rst_n (rst_n),
        .cmp_fall_3v (f3), .cmp_rise_3v (r3),
        .cmp_fall_5v (f5), .cmp_rise_5v (r5),
        .cfg_range_5v (rng5), .cfg_power_off (pwr_off),
        .cfg_reset_off (rst_off), .cfg_stop_keep (stop_keep),
        .stop_in (stop),
        .lv_status (lv_status), .lv_reset_req (lv_reset_req)
    );

    // Requirement model state
    logic [3:0] m_pipe [LAT];
    logic m_lat, m_st, m_rr;

    // R4, R6: block enabled when powered and not frozen by stop
    function automatic logic f_enabled(logic p, logic s, logic k);
        return !p && !(s && !k);
    endfunction

    // R2, R3, R4, R6: next latch value from the selected pair
    function automatic logic f_next_lat(logic cur, logic [3:0] sy, logic r,
                                        logic p, logic s, logic k);
        logic fall, rise;
        fall = r ? sy[3] : sy[1];
        rise = r ? sy[2] : sy[0];
        if (p) return 1'b1;
        if (s && !k) return cur;
        if (fall) return 1'b1;
        if (rise) return 1'b0;
        return cur;
    endfunction

    // Model advance at every edge (R9 latency via the pipe)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) m_pipe[i] <= 4'b0;
            m_lat <= 1'b1;
            m_st  <= 1'b0;
            m_rr  <= 1'b0;
        end else begin
            m_pipe[0] <= {f5, r5, f3, r3};
            for (int i = 1; i < LAT; i++) m_pipe[i] <= m_pipe[i-1];
            m_lat <= f_next_lat(m_lat, m_pipe[LAT-1], rng5, pwr_off, stop, stop_keep);
            m_st  <= m_lat && f_enabled(pwr_off, stop, stop_keep);
            m_rr  <= m_st && f_enabled(pwr_off, stop, stop_keep) && !rst_off;
        end
    end

    task automatic check_now();
        checks++;
        if (lv_status !== m_st) begin
            fails++;
            $display("FAIL %s lv_status actual=%b expected=%b at %0t",
                     cur_req, lv_status, m_st, $time);
        end
        checks++;
        if (lv_reset_req !== m_rr) begin
            fails++;
            $display("FAIL %s lv_reset_req actual=%b expected=%b at %0t",
                     cur_req, lv_reset_req, m_rr, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            check_now();
        end
    endtask

    // Single fixed-value check for directed corner cases
    task automatic expect_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1a7e));
        // R8: outputs low in reset, status 1 right after release
        cur_req = "R8";
        step(3);
        expect_bit("R8 reset status", lv_status, 1'b0);
        rst_n = 1'b1;
        step(1);
        expect_bit("R8 status after reset", lv_status, 1'b1);
        step(2);
        // R9: good supply clears status on the 4th edge
        cur_req = "R9";
        r3 = 1'b1;
        step(3);
        expect_bit("R9 before latency", lv_status, 1'b1);
        step(1);
        expect_bit("R9 at latency", lv_status, 1'b0);
        step(3);
        // R1: low supply sets status
        cur_req = "R1";
        r3 = 1'b0; f3 = 1'b1;
        step(6);
        expect_bit("R1 status set", lv_status, 1'b1);
        // R2: both idle holds, both set keeps it set
        cur_req = "R2";
        f3 = 1'b0;
        step(6);
        expect_bit("R2 hold", lv_status, 1'b1);
        f3 = 1'b1; r3 = 1'b1;
        step(6);
        expect_bit("R2 fall priority", lv_status, 1'b1);
        // R3: select 5V pair, 3V pair says low but is ignored
        cur_req = "R3";
        rng5 = 1'b1; r5 = 1'b1; f5 = 1'b0;
        step(6);
        expect_bit("R3 5V pair used", lv_status, 1'b0);
        // R5: reset suppressed while status still polls
        cur_req = "R5";
        rst_off = 1'b1; r5 = 1'b0; f5 = 1'b1;
        step(6);
        expect_bit("R5 status", lv_status, 1'b1);
        expect_bit("R5 reset off", lv_reset_req, 1'b0);
        // R7: reset follows once re-enabled, releases after status
        cur_req = "R7";
        rst_off = 1'b0;
        step(1);
        expect_bit("R7 reset asserted", lv_reset_req, 1'b1);
        f5 = 1'b0; r5 = 1'b1;
        step(8);
        expect_bit("R7 reset released", lv_reset_req, 1'b0);
        // R4: power down quiets outputs, reloads improper
        cur_req = "R4";
        pwr_off = 1'b1;
        step(3);
        expect_bit("R4 off status", lv_status, 1'b0);
        r5 = 1'b0;
        step(3);
        pwr_off = 1'b0;
        step(3);
        expect_bit("R4 reload improper", lv_status, 1'b1);
        // R6: stop without keep freezes; with keep detection continues
        cur_req = "R6";
        r5 = 1'b1;
        step(6);
        stop = 1'b1; stop_keep = 1'b0; r5 = 1'b0; f5 = 1'b1;
        step(6);
        expect_bit("R6 frozen status", lv_status, 1'b0);
        f5 = 1'b0;
        step(3);
        stop = 1'b0;
        step(2);
        expect_bit("R6 latch held good", lv_status, 1'b0);
        stop = 1'b1; stop_keep = 1'b1; f5 = 1'b1;
        step(6);
        expect_bit("R6 keep detects", lv_status, 1'b1);
        stop = 1'b0; f5 = 1'b0;
        // Random phase covers all requirements together (R1..R9 mix)
        cur_req = "R2 random";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                f3 = 1'($urandom); r3 = 1'($urandom);
                f5 = 1'($urandom); r5 = 1'($urandom);
            end
            if ($urandom_range(0, 39) == 0) rng5      = 1'($urandom);
            if ($urandom_range(0, 59) == 0) pwr_off   = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 39) == 0) rst_off   = 1'($urandom);
            if ($urandom_range(0, 39) == 0) stop      = 1'($urandom);
            if ($urandom_range(0, 39) == 0) stop_keep = 1'($urandom);
            if ($urandom_range(0, 499) == 0) rst_n    = 1'b0;
            else                             rst_n    = 1'b1;
            step(1);
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule